// File: doc/BRIEF.md
# Status-Decoding Bus Command Controller

This block sits next to a processor that announces each bus cycle with a 3-bit status code rather than with discrete read and write strobes. It watches that code, detects the start of a cycle when the code leaves the idle (passive) value, and then drives the system bus: an address-latch pulse first, then the matching active-low memory, I/O or interrupt-acknowledge command, plus transceiver direction and data enable.

Writes produce two strobes: an early write strobe that gives slow devices extra set-up time, and a normal write strobe one clock later. All commands and the data enable are qualified by an active-high command-enable input and by an active-low address-enable input. After address-enable falls, the outputs may assert only once a programmable number of clocks has passed.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: Status decode, with status[2:0] given as a 3-bit value: 000 drives `inta_n`, 001 drives `io_rd_n`, 010 drives `io_wr_n` and `io_wr_early_n`, 100 and 101 drive `mem_rd_n`, and 110 drives `mem_wr_n` and `mem_wr_early_n`. At most one command class is active at a time.
- R2: Codes 011 (halt) and 111 (passive) never assert any command output.
- R3: All command outputs are active-low. They are high during reset and whenever no cycle is running.
- R4: A cycle starts at the clock edge where the sampled status changes from 111 to any other code. `ale` is high for exactly the clock that follows that edge (the latch clock).
- R5: Read strobes, interrupt acknowledge and the early write strobes become active in the second clock of the cycle. The normal write strobes become active in the third clock. No command is active during the latch clock.
- R6: Every strobe releases in the clock after the edge that samples status 111. A cycle that returns to 111 early ends at that point.
- R7: `dir_tx` is high from the latch clock onward in write cycles (010, 110). It is low in all other cycles and when idle.
- R8: `data_en` is high from the second clock of a cycle until its release, for every code except halt.
- R9: While `cmd_en` is low, all commands are inactive and `data_en` is low.
- R10: Commands and `data_en` can assert only after `addr_en_n` has been sampled low on ENABLE_DLY consecutive edges. `addr_en_n` high cancels the count and blocks the outputs at once.
- R11: A change between two non-passive codes does not start a new cycle. A new cycle needs an intervening 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status | input | 3 | Processor bus status code |
| addr_en_n | input | 1 | Active-low address enable |
| cmd_en | input | 1 | Active-high command enable |
| ale | output | 1 | Address-latch pulse |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command |
| mem_wr_early_n | output | 1 | Early memory write command |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command |
| io_wr_early_n | output | 1 | Early I/O write command |
| inta_n | output | 1 | Interrupt acknowledge |
| dir_tx | output | 1 | Transceiver direction, high for writes |
| data_en | output | 1 | Transceiver data enable |

## Verification
The bench builds the block with ENABLE_DLY = 2. With that value the enable window is crossed within a couple of clocks, so a single run exercises three states: commands blocked while the count is still running, commands cut off partway through a write when address-enable rises, and normal operation. Cycles of one, two and several clocks cover early release between the latch clock and the normal write strobe. Back-to-back codes that skip the passive state check that no spurious cycle starts.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LATCH  = 2'd1,
    PH_EARLY  = 2'd2,
    PH_FULL   = 2'd3
  } bcc_phase_t;

  localparam logic [2:0] ST_INTA   = 3'b000;
  localparam logic [2:0] ST_IORD   = 3'b001;
  localparam logic [2:0] ST_IOWR   = 3'b010;
  localparam logic [2:0] ST_HALT   = 3'b011;
  localparam logic [2:0] ST_FETCH  = 3'b100;
  localparam logic [2:0] ST_MEMRD  = 3'b101;
  localparam logic [2:0] ST_MEMWR  = 3'b110;
  localparam logic [2:0] ST_IDLE   = 3'b111;
endpackage

// File: rtl/bcc_sequencer.sv
module bcc_sequencer
  import bcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] status,
  output bcc_phase_t phase_o,
  output logic [2:0] code_o
);
  logic [2:0] prev_q, code_q, code_d;
  bcc_phase_t ph_q, ph_d;

  always_comb begin
    ph_d   = ph_q;
    code_d = code_q;
    if (status == ST_IDLE) begin
      ph_d = PH_IDLE;
    end else if (prev_q == ST_IDLE) begin
      ph_d   = PH_LATCH;
      code_d = status;
    end else begin
      unique case (ph_q)
        PH_LATCH: ph_d = PH_EARLY;
        PH_EARLY: ph_d = PH_FULL;
        default:  ph_d = ph_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= ST_IDLE;
      code_q <= ST_IDLE;
      ph_q   <= PH_IDLE;
    end else begin
      prev_q <= status;
      code_q <= code_d;
      ph_q   <= ph_d;
    end
  end

  assign phase_o = ph_q;
  assign code_o  = code_q;
endmodule

// File: rtl/bcc_enable_timer.sv
module bcc_enable_timer #(
  parameter int unsigned ENABLE_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_en_n,
  input  logic cmd_en,
  output logic gate_o
);
  generate
    if (ENABLE_DLY == 0) begin : g_nodly
      assign gate_o = cmd_en && !addr_en_n;
    end else begin : g_dly
      localparam int unsigned CW = $clog2(ENABLE_DLY + 1);
      localparam logic [CW-1:0] LIMIT = CW'(ENABLE_DLY);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign cnt_en = addr_en_n || (cnt_q != LIMIT);

      always_comb begin
        if (addr_en_n) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign gate_o = cmd_en && !addr_en_n && (cnt_q == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/bcc_cmd_decode.sv
module bcc_cmd_decode
  import bcc_pkg::*;
(
  input  bcc_phase_t phase,
  input  logic [2:0] code,
  input  logic       gate,
  output logic       ale,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       mem_wr_early_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       io_wr_early_n,
  output logic       inta_n,
  output logic       dir_tx,
  output logic       data_en
);
  logic strobe_win, full_win, is_write;

  assign strobe_win = gate && (phase == PH_EARLY || phase == PH_FULL);
  assign full_win   = gate && (phase == PH_FULL);
  assign is_write   = (code == ST_IOWR) || (code == ST_MEMWR);

  always_comb begin
    ale            = (phase == PH_LATCH);
    dir_tx         = (phase != PH_IDLE) && is_write;
    data_en        = strobe_win && (code != ST_HALT);
    inta_n         = !(strobe_win && code == ST_INTA);
    io_rd_n        = !(strobe_win && code == ST_IORD);
    io_wr_early_n  = !(strobe_win && code == ST_IOWR);
    io_wr_n        = !(full_win   && code == ST_IOWR);
    mem_rd_n       = !(strobe_win && (code == ST_FETCH || code == ST_MEMRD));
    mem_wr_early_n = !(strobe_win && code == ST_MEMWR);
    mem_wr_n       = !(full_win   && code == ST_MEMWR);
  end
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bcc_pkg::*;
#(
  parameter int unsigned ENABLE_DLY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] status,
  input  logic       addr_en_n,
  input  logic       cmd_en,
  output logic       ale,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       mem_wr_early_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       io_wr_early_n,
  output logic       inta_n,
  output logic       dir_tx,
  output logic       data_en
);
  bcc_phase_t phase;
  logic [2:0] code;
  logic       gate;

  bcc_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .status(status), .phase_o(phase), .code_o(code)
  );

  bcc_enable_timer #(.ENABLE_DLY(ENABLE_DLY)) u_tmr (
    .clk(clk), .rst_n(rst_n), .addr_en_n(addr_en_n), .cmd_en(cmd_en), .gate_o(gate)
  );

  bcc_cmd_decode u_dec (
    .phase(phase), .code(code), .gate(gate),
    .ale(ale), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_wr_early_n(mem_wr_early_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .io_wr_early_n(io_wr_early_n), .inta_n(inta_n), .dir_tx(dir_tx),
    .data_en(data_en)
  );
endmodule

// File: rtl/bus_cmd_ctrl_checker.sv
module bus_cmd_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] status,
  input logic       addr_en_n,
  input logic       cmd_en,
  input logic       ale,
  input logic       mem_rd_n,
  input logic       mem_wr_n,
  input logic       mem_wr_early_n,
  input logic       io_rd_n,
  input logic       io_wr_n,
  input logic       io_wr_early_n,
  input logic       inta_n,
  input logic       dir_tx,
  input logic       data_en
);
  logic any_cmd;
  assign any_cmd = !(mem_rd_n && mem_wr_n && mem_wr_early_n && io_rd_n &&
                     io_wr_n && io_wr_early_n && inta_n);

  a_r1_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!inta_n, !io_rd_n, !io_wr_early_n, !mem_rd_n, !mem_wr_early_n}));

  a_r4_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r5_quiet_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !any_cmd);

  a_r5_early_covers_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n |-> !mem_wr_early_n) and (!io_wr_n |-> !io_wr_early_n));

  a_r6_release_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'b111) |=> !any_cmd && !data_en && !ale);

  a_r7_write_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_early_n || !io_wr_early_n) |-> dir_tx);

  a_r9_cmd_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |-> !any_cmd && !data_en);

  a_r10_addr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en_n |-> !any_cmd && !data_en);
endmodule

bind bus_cmd_ctrl bus_cmd_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .addr_en_n(addr_en_n),
  .cmd_en(cmd_en), .ale(ale), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .mem_wr_early_n(mem_wr_early_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
  .io_wr_early_n(io_wr_early_n), .inta_n(inta_n), .dir_tx(dir_tx),
  .data_en(data_en)
);

// File: tb/bus_cmd_ctrl_bench.sv
module bus_cmd_ctrl_bench;
  localparam int DLY = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] status = 3'b111;
  logic       addr_en_n = 1'b1;
  logic       cmd_en = 1'b0;
  logic ale, mem_rd_n, mem_wr_n, mem_wr_early_n, io_rd_n, io_wr_n;
  logic io_wr_early_n, inta_n, dir_tx, data_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_cmd_ctrl #(.ENABLE_DLY(DLY)) u_bus_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .status(status), .addr_en_n(addr_en_n),
    .cmd_en(cmd_en), .ale(ale), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_wr_early_n(mem_wr_early_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .io_wr_early_n(io_wr_early_n), .inta_n(inta_n), .dir_tx(dir_tx),
    .data_en(data_en)
  );

  // Reference model: clock index inside the current cycle (0 = idle).
  int m_prev = 7;
  int m_step = 0;
  int m_code = 7;
  int m_cnt  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 7; m_step = 0; m_code = 7; m_cnt = 0;
    end else begin
      if (addr_en_n) m_cnt = 0;
      else if (m_cnt < DLY) m_cnt = m_cnt + 1;
      if (int'(status) == 7) m_step = 0;
      else if (m_prev == 7) begin m_step = 1; m_code = int'(status); end
      else if (m_step > 0 && m_step < 3) m_step = m_step + 1;
      m_prev = int'(status);
    end
  end

  task automatic chk(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, name, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit g, s, f, wr;
      g  = cmd_en && !addr_en_n && (m_cnt >= DLY);
      s  = g && (m_step >= 2);
      f  = g && (m_step >= 3);
      wr = (m_code == 2) || (m_code == 6);
      chk("R4",  "ale",            ale,            m_step == 1);
      chk("R1",  "inta_n",         inta_n,         !(s && m_code == 0));
      chk("R1",  "io_rd_n",        io_rd_n,        !(s && m_code == 1));
      chk("R5",  "io_wr_early_n",  io_wr_early_n,  !(s && m_code == 2));
      chk("R5",  "io_wr_n",        io_wr_n,        !(f && m_code == 2));
      chk("R1",  "mem_rd_n",       mem_rd_n,       !(s && (m_code == 4 || m_code == 5)));
      chk("R5",  "mem_wr_early_n", mem_wr_early_n, !(s && m_code == 6));
      chk("R5",  "mem_wr_n",       mem_wr_n,       !(f && m_code == 6));
      chk("R7",  "dir_tx",         dir_tx,         (m_step > 0) && wr);
      chk("R8",  "data_en",        data_en,        s && m_code != 3);
    end
  end

  task automatic step(logic [2:0] st, logic aen_n, logic ce);
    @(posedge clk); #1;
    status = st; addr_en_n = aen_n; cmd_en = ce;
  endtask

  task automatic bus_cycle(logic [2:0] st, int len, logic aen_n, logic ce);
    for (int i = 0; i < len; i++) step(st, aen_n, ce);
    step(3'b111, aen_n, ce);
    step(3'b111, aen_n, ce);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R3: command outputs idle high while in reset.
    chk("R3", "reset mem_rd_n", mem_rd_n, 1'b1);
    chk("R3", "reset inta_n", inta_n, 1'b1);
    #1 rst_n = 1'b1;
    // R10: commands are blocked while the enable count runs.
    step(3'b111, 1'b0, 1'b1);
    bus_cycle(3'b001, 4, 1'b0, 1'b1);
    // R1, R2, R5, R6: all codes with a settled enable.
    for (int c = 0; c < 8; c++) bus_cycle(3'(c), 5, 1'b0, 1'b1);
    // R6: short cycles ending in the latch clock and in the early clock.
    bus_cycle(3'b110, 1, 1'b0, 1'b1);
    bus_cycle(3'b110, 2, 1'b0, 1'b1);
    bus_cycle(3'b010, 2, 1'b0, 1'b1);
    // R9: command enable low.
    bus_cycle(3'b101, 5, 1'b0, 1'b0);
    bus_cycle(3'b110, 5, 1'b0, 1'b0);
    // R10: address enable rises during a write, then falls again.
    step(3'b110, 1'b0, 1'b1);
    step(3'b110, 1'b0, 1'b1);
    step(3'b110, 1'b0, 1'b1);
    step(3'b110, 1'b1, 1'b1);
    step(3'b110, 1'b0, 1'b1);
    step(3'b110, 1'b0, 1'b1);
    step(3'b110, 1'b0, 1'b1);
    step(3'b111, 1'b0, 1'b1);
    // R11: codes change without a passive gap.
    step(3'b001, 1'b0, 1'b1);
    step(3'b001, 1'b0, 1'b1);
    step(3'b101, 1'b0, 1'b1);
    step(3'b110, 1'b0, 1'b1);
    step(3'b000, 1'b0, 1'b1);
    step(3'b111, 1'b0, 1'b1);
    step(3'b111, 1'b0, 1'b1);
    // Mixed sequence over all inputs.
    for (int k = 0; k < 300; k++)
      step(3'((k * 5 + k / 7) % 8), (k % 23) == 4, (k % 17) != 9);
    bus_cycle(3'b010, 4, 1'b0, 1'b1);
    @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule